// File: doc/BRIEF.md
# Multi-PID Translation Buffer with Invalidate Snooping

This block is a small, fully associative translation buffer. A lookup presents an effective page number, the privilege mode and the access kind. The page number is compared against every valid entry under three process identifiers at once. An entry tagged with identifier zero is a shared page and matches under any identifier. One cycle later the block returns the real page number, the four user attribute bits, a hit flag, a flag for more than one match, and a fault flag when the entry's permissions do not allow the access.

Software manages the entries through a set of holding registers. It can copy an entry into them, store them into an entry, or search by page number. A search that misses loads the holding registers from a default register. A local invalidate clears every entry with a given page number, and it can be forwarded to the system bus. Invalidates snooped from the bus clear local entries in the same way. If an invalidate arrives together with a write, the invalidate goes first and the write is applied one cycle later.

Top module: `mpid_tlb`

## Requirements
- R1: After reset every entry is invalid, all three identifier registers are zero, and the holding and default registers are zero.
- R2: A lookup hits an entry when the entry is valid, its page number equals the key, and its tag equals any of the three identifier registers. `lk_done` and all result outputs appear in the cycle after `lk_req`.
- R3: An entry with tag zero matches on its page number alone, whatever the identifier registers hold.
- R4: On a single hit, `lk_fault` is set when permission bit `2*acc+user` is clear. The permission bits are: bit0 supervisor read, bit1 user read, bit2 supervisor write, bit3 user write, bit4 supervisor execute, bit5 user execute. `acc` is 0 for read, 1 for write, 2 for execute, and 3 is treated as read. `user` is 1 in user mode.
- R5: When two or more entries match, `lk_multi` is set, while `lk_hit` and `lk_fault` stay clear and `lk_rpn` is zero.
- R6: Operation code 1 (read) copies entry `hold_idx` into the holding registers. Operation code 2 (write) stores the holding registers into entry `hold_idx`. Both take effect at the clock edge where the operation is sampled.
- R7: Operation code 3 (search) matches `srch_epn` under the identifier rules. On a single hit it loads the holding registers with that entry and its index. On a miss, or on more than one match, it loads index, tag and attributes from the default register, the page number from `srch_epn`, and clears valid, real page and permissions.
- R8: A local invalidate clears every valid entry whose page number matches, whatever its tag. When `bcast_en` is high, the next cycle shows `bus_inv_valid` high with the same page number. Otherwise `bus_inv_valid` stays low.
- R9: A snooped invalidate clears matching entries in the same way as a local invalidate, and it is never forwarded to the bus.
- R10: A write that meets an invalidate in the same cycle is held back, and it lands at the following clock edge. A lookup sampled at that edge still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pid_wr_en | input | 1 | Write an identifier register |
| pid_wr_sel | input | 2 | Identifier register select (0..2) |
| pid_wr_data | input | 8 | Identifier value |
| lk_req | input | 1 | Lookup request |
| lk_epn | input | 20 | Lookup page number |
| lk_user | input | 1 | 1 = user mode, 0 = supervisor |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Single valid match |
| lk_multi | output | 1 | More than one match |
| lk_fault | output | 1 | Permission violation on a hit |
| lk_rpn | output | 20 | Real page number |
| lk_attr | output | 4 | User attribute bits |
| op | input | 2 | 0 none, 1 read, 2 write, 3 search |
| srch_epn | input | 20 | Search page number |
| hold_ld | input | 1 | Load holding registers from hold_in_* |
| hold_in_idx | input | 4 | Entry index |
| hold_in_vld | input | 1 | Valid bit |
| hold_in_epn | input | 20 | Page number |
| hold_in_tid | input | 8 | Tag |
| hold_in_rpn | input | 20 | Real page number |
| hold_in_attr | input | 4 | Attributes |
| hold_in_perm | input | 6 | Permission bits |
| hold_idx | output | 4 | Holding index |
| hold_vld | output | 1 | Holding valid bit |
| hold_epn | output | 20 | Holding page number |
| hold_tid | output | 8 | Holding tag |
| hold_rpn | output | 20 | Holding real page |
| hold_attr | output | 4 | Holding attributes |
| hold_perm | output | 6 | Holding permissions |
| dflt_ld | input | 1 | Load default register |
| dflt_in_idx | input | 4 | Default index |
| dflt_in_tid | input | 8 | Default tag |
| dflt_in_attr | input | 4 | Default attributes |
| inv_valid | input | 1 | Local invalidate |
| inv_epn | input | 20 | Local invalidate page number |
| bcast_en | input | 1 | Forward local invalidates to the bus |
| bus_inv_valid | output | 1 | Forwarded invalidate |
| bus_inv_epn | output | 20 | Forwarded page number |
| snp_valid | input | 1 | Snooped invalidate |
| snp_epn | input | 20 | Snooped page number |

## Verification
Lookup results are due one cycle after `lk_req`. The driver queues an expected result when it raises the request. The monitor removes one item for each `lk_done` and compares it half a cycle after that edge. Holding-register and bus-forwarding effects are due one edge after the operation, so they are read at the falling edge that follows it. Entry-array changes, whether from writes, invalidates or a delayed write, are checked through a later lookup. For the write delayed by an invalidate, a lookup is placed on purpose at the retry edge so that it must still miss, and the next lookup must hit.

// File: rtl/mpid_tlb_pkg.sv
package mpid_tlb_pkg;
  localparam int EPN_W  = 20;
  localparam int RPN_W  = 20;
  localparam int TID_W  = 8;
  localparam int ATTR_W = 4;
  localparam int PERM_W = 6;

  typedef struct packed {
    logic              vld;
    logic [EPN_W-1:0]  epn;
    logic [TID_W-1:0]  tid;
    logic [RPN_W-1:0]  rpn;
    logic [ATTR_W-1:0] attr;
    logic [PERM_W-1:0] perm;
  } tlb_ent_t;

  typedef enum logic [1:0] {OP_NONE = 2'd0, OP_READ = 2'd1, OP_WRITE = 2'd2, OP_SRCH = 2'd3} tlb_op_e;

  // permission bit index = 2*kind + user, kind 3 folds onto read
  function automatic logic perm_ok(logic [PERM_W-1:0] perm, logic [1:0] acc, logic user);
    logic [1:0] kind;
    logic [2:0] bi;
    kind = (acc == 2'd3) ? 2'd0 : acc;
    bi   = {kind, user};
    return perm[bi];
  endfunction
endpackage

// File: rtl/mpid_tlb_cam.sv
module mpid_tlb_cam
  import mpid_tlb_pkg::*;
#(
  parameter int N_ENT = 16,
  parameter int N_PID = 3
) (
  input  tlb_ent_t                      ents [N_ENT],
  input  logic [EPN_W-1:0]              key,
  input  logic [N_PID-1:0][TID_W-1:0]   pids,
  input  logic                          use_tid,
  output logic [N_ENT-1:0]              hits
);
  function automatic logic tag_ok(logic [TID_W-1:0] tid, logic [N_PID-1:0][TID_W-1:0] p);
    logic ok;
    ok = (tid == '0);
    for (int k = 0; k < N_PID; k++) ok = ok | (tid == p[k]);
    return ok;
  endfunction

  for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
    assign hits[i] = ents[i].vld && (ents[i].epn == key) &&
                     (!use_tid || tag_ok(ents[i].tid, pids));
  end
endmodule

// File: rtl/mpid_tlb_pick.sv
module mpid_tlb_pick #(
  parameter int N_ENT = 16,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic [N_ENT-1:0] hits,
  output logic             any,
  output logic             multi,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < N_ENT; i++)
      if (hits[i]) idx = IDX_W'(i);
  end
  assign any   = |hits;
  assign multi = $countones(hits) > 1;
endmodule

// File: rtl/mpid_tlb.sv
module mpid_tlb
  import mpid_tlb_pkg::*;
#(
  parameter int N_ENT = 16,
  parameter int N_PID = 3,
  localparam int IDX_W  = $clog2(N_ENT),
  localparam int PSEL_W = (N_PID > 1) ? $clog2(N_PID) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pid_wr_en,
  input  logic [PSEL_W-1:0] pid_wr_sel,
  input  logic [TID_W-1:0]  pid_wr_data,
  input  logic              lk_req,
  input  logic [EPN_W-1:0]  lk_epn,
  input  logic              lk_user,
  input  logic [1:0]        lk_acc,
  output logic              lk_done,
  output logic              lk_hit,
  output logic              lk_multi,
  output logic              lk_fault,
  output logic [RPN_W-1:0]  lk_rpn,
  output logic [ATTR_W-1:0] lk_attr,
  input  logic [1:0]        op,
  input  logic [EPN_W-1:0]  srch_epn,
  input  logic              hold_ld,
  input  logic [IDX_W-1:0]  hold_in_idx,
  input  logic              hold_in_vld,
  input  logic [EPN_W-1:0]  hold_in_epn,
  input  logic [TID_W-1:0]  hold_in_tid,
  input  logic [RPN_W-1:0]  hold_in_rpn,
  input  logic [ATTR_W-1:0] hold_in_attr,
  input  logic [PERM_W-1:0] hold_in_perm,
  output logic [IDX_W-1:0]  hold_idx,
  output logic              hold_vld,
  output logic [EPN_W-1:0]  hold_epn,
  output logic [TID_W-1:0]  hold_tid,
  output logic [RPN_W-1:0]  hold_rpn,
  output logic [ATTR_W-1:0] hold_attr,
  output logic [PERM_W-1:0] hold_perm,
  input  logic              dflt_ld,
  input  logic [IDX_W-1:0]  dflt_in_idx,
  input  logic [TID_W-1:0]  dflt_in_tid,
  input  logic [ATTR_W-1:0] dflt_in_attr,
  input  logic              inv_valid,
  input  logic [EPN_W-1:0]  inv_epn,
  input  logic              bcast_en,
  output logic              bus_inv_valid,
  output logic [EPN_W-1:0]  bus_inv_epn,
  input  logic              snp_valid,
  input  logic [EPN_W-1:0]  snp_epn
);
  tlb_ent_t                    ent_q [N_ENT];
  logic [N_PID-1:0][TID_W-1:0] pid_q;
  tlb_ent_t                    hold_q;
  logic [IDX_W-1:0]            hold_idx_q;
  logic [IDX_W-1:0]            dflt_idx_q;
  logic [TID_W-1:0]            dflt_tid_q;
  logic [ATTR_W-1:0]           dflt_attr_q;

  // named internal events
  logic [N_ENT-1:0] lk_hits, sr_hits, il_hits, sn_hits, inv_clear;
  logic             lk_any, lk_mul, sr_any, sr_mul;
  logic [IDX_W-1:0] lk_idx, sr_idx;
  logic             inv_any, wr_req, wr_blocked, wr_do, wr_retry;
  logic             srch_go, srch_hit;
  tlb_ent_t         lk_ent;

  mpid_tlb_cam #(.N_ENT(N_ENT), .N_PID(N_PID)) u_cam_lk (
    .ents(ent_q), .key(lk_epn), .pids(pid_q), .use_tid(1'b1), .hits(lk_hits));
  mpid_tlb_cam #(.N_ENT(N_ENT), .N_PID(N_PID)) u_cam_sr (
    .ents(ent_q), .key(srch_epn), .pids(pid_q), .use_tid(1'b1), .hits(sr_hits));
  mpid_tlb_cam #(.N_ENT(N_ENT), .N_PID(N_PID)) u_cam_il (
    .ents(ent_q), .key(inv_epn), .pids(pid_q), .use_tid(1'b0), .hits(il_hits));
  mpid_tlb_cam #(.N_ENT(N_ENT), .N_PID(N_PID)) u_cam_sn (
    .ents(ent_q), .key(snp_epn), .pids(pid_q), .use_tid(1'b0), .hits(sn_hits));

  mpid_tlb_pick #(.N_ENT(N_ENT)) u_pick_lk (.hits(lk_hits), .any(lk_any), .multi(lk_mul), .idx(lk_idx));
  mpid_tlb_pick #(.N_ENT(N_ENT)) u_pick_sr (.hits(sr_hits), .any(sr_any), .multi(sr_mul), .idx(sr_idx));

  assign inv_clear  = ({N_ENT{inv_valid}} & il_hits) | ({N_ENT{snp_valid}} & sn_hits);
  assign inv_any    = inv_valid | snp_valid;
  assign wr_req     = (op == OP_WRITE) | wr_retry;
  assign wr_blocked = wr_req & inv_any;
  assign wr_do      = wr_req & ~inv_any;
  assign srch_go    = (op == OP_SRCH);
  assign srch_hit   = sr_any & ~sr_mul;
  assign lk_ent     = ent_q[lk_idx];

  // entry array: invalidate wins over write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) ent_q[i] <= '0;
      wr_retry <= 1'b0;
    end else begin
      wr_retry <= wr_blocked;
      for (int i = 0; i < N_ENT; i++) begin
        if (wr_do && hold_idx_q == IDX_W'(i)) ent_q[i] <= hold_q;
        else if (inv_clear[i])                ent_q[i].vld <= 1'b0;
      end
    end
  end

  // identifier and default registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pid_q       <= '0;
      dflt_idx_q  <= '0;
      dflt_tid_q  <= '0;
      dflt_attr_q <= '0;
    end else begin
      for (int p = 0; p < N_PID; p++)
        if (pid_wr_en && pid_wr_sel == PSEL_W'(p)) pid_q[p] <= pid_wr_data;
      if (dflt_ld) begin
        dflt_idx_q  <= dflt_in_idx;
        dflt_tid_q  <= dflt_in_tid;
        dflt_attr_q <= dflt_in_attr;
      end
    end
  end

  // holding registers: read / search take precedence over a direct load
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q     <= '0;
      hold_idx_q <= '0;
    end else if (op == OP_READ) begin
      hold_q <= ent_q[hold_idx_q];
    end else if (srch_go && srch_hit) begin
      hold_q     <= ent_q[sr_idx];
      hold_idx_q <= sr_idx;
    end else if (srch_go) begin
      hold_q      <= '0;
      hold_q.epn  <= srch_epn;
      hold_q.tid  <= dflt_tid_q;
      hold_q.attr <= dflt_attr_q;
      hold_idx_q  <= dflt_idx_q;
    end else if (hold_ld) begin
      hold_q     <= '{vld: hold_in_vld, epn: hold_in_epn, tid: hold_in_tid,
                      rpn: hold_in_rpn, attr: hold_in_attr, perm: hold_in_perm};
      hold_idx_q <= hold_in_idx;
    end
  end

  // registered lookup result and bus forwarding
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_done <= 1'b0; lk_hit <= 1'b0; lk_multi <= 1'b0; lk_fault <= 1'b0;
      lk_rpn <= '0; lk_attr <= '0;
      bus_inv_valid <= 1'b0; bus_inv_epn <= '0;
    end else begin
      lk_done  <= lk_req;
      lk_hit   <= lk_req & lk_any & ~lk_mul;
      lk_multi <= lk_req & lk_mul;
      lk_fault <= lk_req & lk_any & ~lk_mul & ~perm_ok(lk_ent.perm, lk_acc, lk_user);
      lk_rpn   <= (lk_req & lk_any & ~lk_mul) ? lk_ent.rpn  : '0;
      lk_attr  <= (lk_req & lk_any & ~lk_mul) ? lk_ent.attr : '0;
      bus_inv_valid <= inv_valid & bcast_en;
      if (inv_valid & bcast_en) bus_inv_epn <= inv_epn;
    end
  end

  assign hold_idx  = hold_idx_q;
  assign hold_vld  = hold_q.vld;
  assign hold_epn  = hold_q.epn;
  assign hold_tid  = hold_q.tid;
  assign hold_rpn  = hold_q.rpn;
  assign hold_attr = hold_q.attr;
  assign hold_perm = hold_q.perm;
endmodule

// File: rtl/mpid_tlb_chk.sv
module mpid_tlb_chk
  import mpid_tlb_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             lk_req,
  input logic             lk_done,
  input logic             lk_hit,
  input logic             lk_multi,
  input logic             lk_fault,
  input logic [RPN_W-1:0] lk_rpn,
  input logic             inv_valid,
  input logic [EPN_W-1:0] inv_epn,
  input logic             bcast_en,
  input logic             bus_inv_valid,
  input logic [EPN_W-1:0] bus_inv_epn,
  input logic             wr_blocked,
  input logic             wr_retry,
  input logic             srch_go,
  input logic             srch_hit,
  input logic             hold_vld
);
  assert_result_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> lk_done);
  assert_done_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !lk_done);
  assert_fault_only_on_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_hit);
  assert_multi_no_translation_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_multi |-> (!lk_hit && !lk_fault && lk_rpn == '0));
  assert_search_miss_clears_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_go && !srch_hit) |=> !hold_vld);
  assert_forward_local_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && bcast_en) |=> (bus_inv_valid && bus_inv_epn == $past(inv_epn)));
  assert_no_forward_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(inv_valid && bcast_en) |=> !bus_inv_valid);
  assert_write_retried_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> wr_retry);
endmodule

bind mpid_tlb mpid_tlb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_done(lk_done), .lk_hit(lk_hit),
  .lk_multi(lk_multi), .lk_fault(lk_fault), .lk_rpn(lk_rpn), .inv_valid(inv_valid),
  .inv_epn(inv_epn), .bcast_en(bcast_en), .bus_inv_valid(bus_inv_valid),
  .bus_inv_epn(bus_inv_epn), .wr_blocked(wr_blocked), .wr_retry(wr_retry),
  .srch_go(srch_go), .srch_hit(srch_hit), .hold_vld(hold_vld));

// File: tb/tb_mpid_tlb.sv
module tb_mpid_tlb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic pid_wr_en = 0; logic [1:0] pid_wr_sel = 0; logic [7:0] pid_wr_data = 0;
  logic lk_req = 0; logic [19:0] lk_epn = 0; logic lk_user = 0; logic [1:0] lk_acc = 0;
  logic lk_done, lk_hit, lk_multi, lk_fault; logic [19:0] lk_rpn; logic [3:0] lk_attr;
  logic [1:0] op = 0; logic [19:0] srch_epn = 0;
  logic hold_ld = 0; logic [3:0] hold_in_idx = 0; logic hold_in_vld = 0;
  logic [19:0] hold_in_epn = 0; logic [7:0] hold_in_tid = 0; logic [19:0] hold_in_rpn = 0;
  logic [3:0] hold_in_attr = 0; logic [5:0] hold_in_perm = 0;
  logic [3:0] hold_idx; logic hold_vld; logic [19:0] hold_epn; logic [7:0] hold_tid;
  logic [19:0] hold_rpn; logic [3:0] hold_attr; logic [5:0] hold_perm;
  logic dflt_ld = 0; logic [3:0] dflt_in_idx = 0; logic [7:0] dflt_in_tid = 0; logic [3:0] dflt_in_attr = 0;
  logic inv_valid = 0; logic [19:0] inv_epn = 0; logic bcast_en = 0;
  logic bus_inv_valid; logic [19:0] bus_inv_epn;
  logic snp_valid = 0; logic [19:0] snp_epn = 0;

  mpid_tlb dut (.*);

  int n_chk = 0, n_bad = 0;

  typedef struct {logic hit; logic multi; logic fault; logic [19:0] rpn; string tag;} exp_t;
  exp_t sb[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: one expected item per result
  always @(negedge clk) begin
    if (rst_n && lk_done) begin
      if (sb.size() == 0) chk("R2 unexpected result", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " flags"}, {29'd0, lk_hit, lk_multi, lk_fault}, {29'd0, e.hit, e.multi, e.fault});
        chk({e.tag, " rpn"}, {12'd0, lk_rpn}, {12'd0, (e.hit ? e.rpn : 20'd0)});
      end
    end
  end

  // all tasks start just after a falling edge and return at one
  task automatic look(logic [19:0] epn, logic user, logic [1:0] acc,
                      logic hit, logic multi, logic fault, logic [19:0] rpn, string tag);
    exp_t e;
    e.hit = hit; e.multi = multi; e.fault = fault; e.rpn = rpn; e.tag = tag;
    sb.push_back(e);
    lk_req = 1; lk_epn = epn; lk_user = user; lk_acc = acc;
    @(negedge clk); lk_req = 0;
  endtask

  task automatic set_pid(logic [1:0] s, logic [7:0] v);
    pid_wr_en = 1; pid_wr_sel = s; pid_wr_data = v;
    @(negedge clk); pid_wr_en = 0;
  endtask

  task automatic load_hold(logic [3:0] idx, logic [19:0] epn, logic [7:0] tid,
                           logic [19:0] rpn, logic [3:0] attr, logic [5:0] perm);
    hold_ld = 1; hold_in_idx = idx; hold_in_vld = 1; hold_in_epn = epn;
    hold_in_tid = tid; hold_in_rpn = rpn; hold_in_attr = attr; hold_in_perm = perm;
    @(negedge clk); hold_ld = 0;
  endtask

  task automatic put(logic [3:0] idx, logic [19:0] epn, logic [7:0] tid, logic [19:0] rpn, logic [5:0] perm);
    load_hold(idx, epn, tid, rpn, 4'h0, perm);
    op = 2'd2; @(negedge clk); op = 2'd0;
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 hold valid", {31'd0, hold_vld}, 0);
    chk("R1 hold idx", {28'd0, hold_idx}, 0);
    chk("R1 hold epn", {12'd0, hold_epn}, 0);
    chk("R1 bus idle", {31'd0, bus_inv_valid}, 0);
    look(20'h00000, 0, 0, 0, 0, 0, 0, "R1 empty array");

    put(4'd0, 20'h00100, 8'h11, 20'hA0000, 6'h3F);
    look(20'h00100, 1, 0, 0, 0, 0, 0, "R1 PIDs cleared, tag 11 misses");

    set_pid(0, 8'h11); set_pid(1, 8'h22); set_pid(2, 8'h33);
    put(4'd1, 20'h00200, 8'h33, 20'hA1000, 6'h3F);
    put(4'd2, 20'h00300, 8'h00, 20'hA2000, 6'h02);
    put(4'd3, 20'h00400, 8'h55, 20'hA3000, 6'h3F);
    put(4'd4, 20'h00500, 8'h22, 20'hA4000, 6'h3F);
    put(4'd5, 20'h00500, 8'h00, 20'hA5000, 6'h3F);

    look(20'h00100, 1, 0, 1, 0, 0, 20'hA0000, "R2 match via first PID");
    look(20'h00200, 0, 1, 1, 0, 0, 20'hA1000, "R2 match via third PID");
    look(20'h00400, 0, 0, 0, 0, 0, 0, "R2 tag matches no PID");
    look(20'h00300, 1, 0, 1, 0, 0, 20'hA2000, "R3 shared page user read ok");
    look(20'h00300, 1, 1, 1, 0, 1, 20'hA2000, "R4 user write fault");
    look(20'h00300, 0, 0, 1, 0, 1, 20'hA2000, "R4 supervisor read fault");
    look(20'h00300, 1, 2, 1, 0, 1, 20'hA2000, "R4 user execute fault");
    look(20'h00300, 1, 3, 1, 0, 0, 20'hA2000, "R4 kind 3 as read");
    look(20'h00500, 0, 0, 0, 1, 0, 0, "R5 two matches");

    set_pid(1, 8'h55);
    look(20'h00400, 0, 0, 1, 0, 0, 20'hA3000, "R2 after PID change");
    look(20'h00500, 0, 0, 1, 0, 0, 20'hA5000, "R3 shared page sole match");
    set_pid(0, 8'h00);
    look(20'h00100, 1, 0, 0, 0, 0, 0, "R2 first PID changed away");

    // R6 read entry
    load_hold(4'd1, 20'hFFFFF, 8'hEE, 20'h0, 4'hF, 6'h0);
    op = 2'd1; @(negedge clk); op = 2'd0;
    chk("R6 read epn", {12'd0, hold_epn}, 32'h00200);
    chk("R6 read tid", {24'd0, hold_tid}, 32'h33);
    chk("R6 read rpn", {12'd0, hold_rpn}, 32'hA1000);
    chk("R6 read vld", {31'd0, hold_vld}, 1);

    // R7 search hit and miss
    dflt_ld = 1; dflt_in_idx = 4'd7; dflt_in_tid = 8'h44; dflt_in_attr = 4'h5;
    @(negedge clk); dflt_ld = 0;
    srch_epn = 20'h00300; op = 2'd3; @(negedge clk); op = 2'd0;
    chk("R7 hit idx", {28'd0, hold_idx}, 2);
    chk("R7 hit rpn", {12'd0, hold_rpn}, 32'hA2000);
    chk("R7 hit perm", {26'd0, hold_perm}, 32'h02);
    srch_epn = 20'h00999; op = 2'd3; @(negedge clk); op = 2'd0;
    chk("R7 miss idx", {28'd0, hold_idx}, 7);
    chk("R7 miss tid", {24'd0, hold_tid}, 32'h44);
    chk("R7 miss attr", {28'd0, hold_attr}, 5);
    chk("R7 miss epn", {12'd0, hold_epn}, 32'h00999);
    chk("R7 miss vld/rpn/perm", {hold_vld, 5'd0, hold_perm, hold_rpn}, 0);

    // R8 local invalidates
    set_pid(0, 8'h11);
    inv_valid = 1; inv_epn = 20'h00100; bcast_en = 1; @(negedge clk); inv_valid = 0;
    chk("R8 forwarded", {31'd0, bus_inv_valid}, 1);
    chk("R8 forwarded epn", {12'd0, bus_inv_epn}, 32'h00100);
    look(20'h00100, 1, 0, 0, 0, 0, 0, "R8 entry cleared");
    inv_valid = 1; inv_epn = 20'h00200; bcast_en = 0; @(negedge clk); inv_valid = 0;
    chk("R8 not forwarded", {31'd0, bus_inv_valid}, 0);
    look(20'h00200, 0, 0, 0, 0, 0, 0, "R8 cleared without forward");
    put(4'd4, 20'h00500, 8'h55, 20'hA4000, 6'h3F);
    inv_valid = 1; inv_epn = 20'h00500; bcast_en = 1; @(negedge clk); inv_valid = 0; bcast_en = 0;
    look(20'h00500, 0, 0, 0, 0, 0, 0, "R8 all tags cleared");

    // R9 snoop
    bcast_en = 1;
    snp_valid = 1; snp_epn = 20'h00300; @(negedge clk); snp_valid = 0;
    chk("R9 snoop not forwarded", {31'd0, bus_inv_valid}, 0);
    bcast_en = 0;
    look(20'h00300, 1, 0, 0, 0, 0, 0, "R9 snoop cleared");
    look(20'h00400, 0, 0, 1, 0, 0, 20'hA3000, "R9 other entry kept");

    // R10 write meets snoop
    load_hold(4'd8, 20'h00800, 8'h00, 20'hA8000, 4'h0, 6'h3F);
    op = 2'd2; snp_valid = 1; snp_epn = 20'h00800; @(negedge clk); op = 2'd0; snp_valid = 0;
    look(20'h00800, 0, 0, 0, 0, 0, 0, "R10 write not yet visible");
    look(20'h00800, 0, 0, 1, 0, 0, 20'hA8000, "R10 write landed after retry");

    repeat (2) @(negedge clk);
    chk("R2 scoreboard drained", sb.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule